// File: doc/BRIEF.md
# Burst-Capable Wishbone Memory Slave

This block is a single-port on-chip word memory behind a Wishbone classic slave port. It serves plain single accesses and incrementing-address bursts. The cycle-type tag (`cti_i`) and burst-type tag (`bte_i`) announce each burst beat. While a burst runs, the slave works out the address the master will present next. It reads that word one clock ahead, so every beat after the first is acknowledged in the cycle it is presented. Linear bursts and wrapped bursts of 4, 8 and 16 words are supported.

The data path is 32 bits wide with four byte-lane selects, and addresses count words. A master that strays from the predicted address, or that drops `cyc_i`, gets no stale data. The slave abandons its guess and starts a fresh access at whatever address is on the bus.

Top module: `burst_sram_slave`

## Requirements
- R1: A new request with `cti_i` = 3'b000 is acknowledged in the clock cycle after it is first presented. After that acknowledge, `ack_o` is low for at least one cycle, even when the strobe stays high.
- R2: A write updates only the byte lanes whose `sel_i` bit is set. Bit n of `sel_i` guards data bits 8n+7 to 8n.
- R3: With `cti_i` = 3'b010 and `bte_i` = 2'b00, the addresses are N, N+1, N+2, and so on. The first beat takes one wait cycle and every later beat is acknowledged with no wait. Read data on each acknowledge is the word stored at the presented address.
- R4: With `bte_i` = 2'b01, only address bits [1:0] advance, modulo 4, and the upper bits stay fixed. A burst from word 0x21 runs 0x21, 0x22, 0x23, 0x20 with no waits after the first beat.
- R5: With `bte_i` = 2'b10, address bits [2:0] wrap modulo 8. With `bte_i` = 2'b11, address bits [3:0] wrap modulo 16. In both cases each beat after the first has no wait.
- R6: After a beat acknowledged with `cti_i` = 3'b111, the slave stops predicting. `ack_o` is low in the next cycle, even if the master presents the next sequential address.
- R7: A presented address that differs from the predicted one gets no acknowledge in that cycle. That beat is acknowledged one cycle later, with the data of the presented address.
- R8: Deasserting `cyc_i` during a burst gives no acknowledge in that cycle and discards the prediction. A following beat at the would-be next address takes one wait cycle.
- R9: Reads and writes can be mixed within one burst. A read of a word written earlier in the same burst returns the newly written data.
- R10: In reset, and in the first cycle after it, `ack_o` is low and `dat_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe: a beat is presented |
| we_i | input | 1 | 1 = write beat, 0 = read beat |
| adr_i | input | AW | Word address |
| dat_i | input | DW | Write data |
| sel_i | input | DW/8 | Byte-lane enables |
| cti_i | input | 3 | Cycle type: 000 single, 010 incrementing, 111 final beat |
| bte_i | input | 2 | Burst type: 00 linear, 01 wrap 4, 10 wrap 8, 11 wrap 16 |
| dat_o | output | DW | Read data |
| ack_o | output | 1 | Beat acknowledge |

## Verification
The hardest situation to reach from the ports is a prediction that is already in flight when the master breaks away from it. This happens either through an off-sequence address or through a dropped `cyc_i`. The stimulus opens a burst, lets one beat be acknowledged so that a prediction is pending, then presents a jump or releases the cycle on the very next clock. It then counts the wait cycles on the beat that follows. Wrapped bursts start just below a wrap boundary so that the carry-suppression case is hit within a few beats. The mixed burst writes four words and then keeps reading through the wrap point without a break.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam logic [2:0] CTI_SINGLE = 3'b000;
    localparam logic [2:0] CTI_INCR   = 3'b010;
    localparam logic [2:0] CTI_LAST   = 3'b111;

    typedef enum logic [1:0] {
        WRAP_NONE = 2'b00,
        WRAP_4    = 2'b01,
        WRAP_8    = 2'b10,
        WRAP_16   = 2'b11
    } wrap_e;

    // Bits of the word address that advance for a given burst type.
    function automatic logic [31:0] wrap_mask(input logic [1:0] bte);
        case (wrap_e'(bte))
            WRAP_4:  return 32'h0000_0003;
            WRAP_8:  return 32'h0000_0007;
            WRAP_16: return 32'h0000_000F;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Following word address within a burst: the masked bits step by one,
    // the others are held.
    function automatic logic [31:0] step_addr(input logic [31:0] cur,
                                              input logic [1:0]  bte);
        logic [31:0] m;
        m = wrap_mask(bte);
        return (cur & ~m) | ((cur + 32'd1) & m);
    endfunction

endpackage

// File: rtl/bsram_addr_step.sv
module bsram_addr_step
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    bte,
    output logic [AW-1:0] nxt
);
    localparam int PAD = 32 - AW;

    logic [31:0] wide;

    generate
        if (PAD > 0) begin : g_pad
            assign wide = step_addr({{PAD{1'b0}}, cur}, bte);
        end else begin : g_full
            assign wide = step_addr(cur, bte);
        end
    endgenerate

    assign nxt = wide[AW-1:0];
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_adr,
    input  logic [DW-1:0] wr_dat,
    input  logic [DW/8-1:0] wr_sel,
    input  logic [AW-1:0] rd_adr,
    output logic [DW-1:0] rd_dat
);
    localparam int LANES = DW / 8;
    localparam int DEPTH = 1 << AW;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [7:0] store [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && wr_sel[l]) begin
                    store[wr_adr] <= wr_dat[8*l +: 8];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    rd_dat[8*l +: 8] <= 8'h00;
                end else begin
                    rd_dat[8*l +: 8] <= store[rd_adr];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bsram_beat_ctrl.sv
module bsram_beat_ctrl
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc,
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] adr,
    input  logic [2:0]    cti,
    input  logic [1:0]    bte,
    output logic          ack,
    output logic          wr_en,
    output logic [AW-1:0] rd_adr
);
    // Word whose read data sits in the output register, and whether it is live.
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] adr;
    } slot_t;

    slot_t         slot_q;
    logic          req;
    logic          hit;
    logic          keep_going;
    logic [AW-1:0] guess;

    bsram_addr_step #(.AW(AW)) u_step (
        .cur (adr),
        .bte (bte),
        .nxt (guess)
    );

    assign req        = cyc && stb;
    assign hit        = req && slot_q.pend && (adr == slot_q.adr);
    assign keep_going = hit && (cti == CTI_INCR);

    assign ack    = hit;
    assign wr_en  = hit && we;
    assign rd_adr = keep_going ? guess : adr;

    always_ff @(posedge clk) begin
        if (rst || !cyc) begin
            slot_q <= '0;
        end else if (keep_going) begin
            slot_q <= '{pend: 1'b1, adr: guess};
        end else if (req && !hit) begin
            slot_q <= '{pend: 1'b1, adr: adr};
        end else begin
            slot_q <= '0;
        end
    end
endmodule

// File: rtl/burst_sram_slave.sv
module burst_sram_slave
    import burst_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic            we_i,
    input  logic [AW-1:0]   adr_i,
    input  logic [DW-1:0]   dat_i,
    input  logic [DW/8-1:0] sel_i,
    input  logic [2:0]      cti_i,
    input  logic [1:0]      bte_i,
    output logic [DW-1:0]   dat_o,
    output logic            ack_o
);
    logic          wr_en;
    logic [AW-1:0] rd_adr;

    bsram_beat_ctrl #(.AW(AW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cyc    (cyc_i),
        .stb    (stb_i),
        .we     (we_i),
        .adr    (adr_i),
        .cti    (cti_i),
        .bte    (bte_i),
        .ack    (ack_o),
        .wr_en  (wr_en),
        .rd_adr (rd_adr)
    );

    bsram_lanes #(.AW(AW), .DW(DW)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_adr (adr_i),
        .wr_dat (dat_i),
        .wr_sel (sel_i),
        .rd_adr (rd_adr),
        .rd_dat (dat_o)
    );
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cyc_i,
    input logic          stb_i,
    input logic [AW-1:0] adr_i,
    input logic [2:0]    cti_i,
    input logic [1:0]    bte_i,
    input logic          ack_o
);
    function automatic logic [AW-1:0] following(input logic [AW-1:0] a,
                                                input logic [1:0]    b);
        logic [31:0] w;
        w = step_addr(32'(a), b);
        return w[AW-1:0];
    endfunction

    // R1: an acknowledge only answers a live strobe inside a cycle
    assert_ack_needs_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (cyc_i && stb_i));

    // R1: an unanswered request held steady is answered one cycle later
    assert_single_wait_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && stb_i && !ack_o) |=>
        (!(cyc_i && stb_i) || adr_i != $past(adr_i) || ack_o));

    // R6: a beat not tagged incrementing ends prediction
    assert_end_drops_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_o && cti_i != CTI_INCR) |=> !ack_o);

    // R3: the predicted beat is answered with no wait
    assert_burst_no_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (ack_o && cti_i == CTI_INCR) |=>
        (!(cyc_i && stb_i) || adr_i != following($past(adr_i), $past(bte_i)) || ack_o));

    // R7: an off-sequence address is never answered at once
    assert_mismatch_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_o && cti_i == CTI_INCR) |=>
        (!(cyc_i && stb_i) || adr_i == following($past(adr_i), $past(bte_i)) || !ack_o));

    // R8: a released cycle kills any pending beat
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !cyc_i |=> (!ack_o || $past(cyc_i) == 1'b0 && 1'b0) || !ack_o);

    // R10: leaving reset there is nothing to acknowledge
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> !ack_o);
endmodule

bind burst_sram_slave bsram_checker #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cyc_i (cyc_i),
    .stb_i (stb_i),
    .adr_i (adr_i),
    .cti_i (cti_i),
    .bte_i (bte_i),
    .ack_o (ack_o)
);

// File: tb/burst_sram_slave_bench.sv
module burst_sram_slave_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [AW-1:0] adr = '0;
    logic [31:0]   dat = '0;
    logic [3:0]    sel = '0;
    logic [2:0]    cti = '0;
    logic [1:0]    bte = '0;
    logic [31:0]   dat_o;
    logic          ack_o;

    always #2.5 clk = ~clk;

    burst_sram_slave #(.AW(AW), .DW(32)) u_burst_sram_slave (
        .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(dat), .sel_i(sel), .cti_i(cti), .bte_i(bte),
        .dat_o(dat_o), .ack_o(ack_o)
    );

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] model [256];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected word per acknowledged read beat.
    always @(negedge clk) begin
        if (!rst && ack_o && cyc && !we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected read ack", dat_o, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(dat_o === e.data, e.tag, dat_o, e.data);
            end
        end
    end

    // Driver: presents one beat, queues its expected read data, counts waits.
    task automatic beat(input logic [AW-1:0] a, input logic w,
                        input logic [31:0] d, input logic [3:0] s,
                        input logic [2:0] c, input logic [1:0] b,
                        input int exp_waits, input string tag);
        int waits;
        @(posedge clk); #1;
        cyc = 1'b1; stb = 1'b1; adr = a; we = w; dat = d; sel = s; cti = c; bte = b;
        if (!w) exp_q.push_back('{data: model[a], tag: {tag, " data"}});
        waits = 0;
        @(negedge clk);
        while (!ack_o && waits < 20) begin
            waits++;
            @(negedge clk);
        end
        check(waits == exp_waits, {tag, " waits"}, 32'(waits), 32'(exp_waits));
        if (w && ack_o) begin
            for (int l = 0; l < 4; l++) begin
                if (s[l]) model[a][8*l +: 8] = d[8*l +: 8];
            end
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        cyc = 1'b0; stb = 1'b0; we = 1'b0; cti = 3'b000; bte = 2'b00;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ack_o == 1'b0, "R10 ack in reset", 32'(ack_o), 32'h0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(ack_o == 1'b0, "R10 ack after reset", 32'(ack_o), 32'h0);
        check(dat_o == 32'h0, "R10 data after reset", dat_o, 32'h0);

        // R1: single accesses, ack gap with strobe held
        beat(8'h10, 1'b1, 32'h1357_9BDF, 4'hF, 3'b000, 2'b00, 1, "R1 single write");
        @(negedge clk);
        check(ack_o == 1'b0, "R1 gap after ack", 32'(ack_o), 32'h0);
        idle();
        beat(8'h10, 1'b0, 32'h0, 4'hF, 3'b000, 2'b00, 1, "R1 single read");
        idle();

        // R2: byte lanes
        beat(8'h10, 1'b1, 32'hAABB_CCDD, 4'b0101, 3'b000, 2'b00, 1, "R2 lane write");
        idle();
        beat(8'h10, 1'b0, 32'h0, 4'hF, 3'b000, 2'b00, 1, "R2 lane read");
        idle();

        // R3: linear bursts
        beat(8'h00, 1'b1, 32'h7001_0001, 4'hF, 3'b010, 2'b00, 1, "R3 lin wr0");
        beat(8'h01, 1'b1, 32'h7001_0002, 4'hF, 3'b010, 2'b00, 0, "R3 lin wr1");
        beat(8'h02, 1'b1, 32'h7001_0003, 4'hF, 3'b010, 2'b00, 0, "R3 lin wr2");
        beat(8'h03, 1'b1, 32'h7001_0004, 4'hF, 3'b111, 2'b00, 0, "R3 lin wr3");
        idle();
        beat(8'h00, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 1, "R3 lin rd0");
        beat(8'h01, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 0, "R3 lin rd1");
        beat(8'h02, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 0, "R3 lin rd2");
        beat(8'h03, 1'b0, 32'h0, 4'hF, 3'b111, 2'b00, 0, "R3 lin rd3");
        // R6: next sequential address after the final beat is not answered
        @(posedge clk); #1; adr = 8'h04; cti = 3'b010;
        @(negedge clk);
        check(ack_o == 1'b0, "R6 no ack after last beat", 32'(ack_o), 32'h0);
        idle();

        // R4: wrap of 4 from 0x21
        beat(8'h24, 1'b1, 32'h0BAD_0024, 4'hF, 3'b000, 2'b00, 1, "R4 guard write");
        idle();
        beat(8'h21, 1'b1, 32'h4000_0021, 4'hF, 3'b010, 2'b01, 1, "R4 wr 21");
        beat(8'h22, 1'b1, 32'h4000_0022, 4'hF, 3'b010, 2'b01, 0, "R4 wr 22");
        beat(8'h23, 1'b1, 32'h4000_0023, 4'hF, 3'b010, 2'b01, 0, "R4 wr 23");
        beat(8'h20, 1'b1, 32'h4000_0020, 4'hF, 3'b111, 2'b01, 0, "R4 wr 20");
        idle();
        beat(8'h21, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 1, "R4 rd 21");
        beat(8'h22, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 0, "R4 rd 22");
        beat(8'h23, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 0, "R4 rd 23");
        beat(8'h20, 1'b0, 32'h0, 4'hF, 3'b111, 2'b01, 0, "R4 rd 20");
        idle();
        beat(8'h24, 1'b0, 32'h0, 4'hF, 3'b000, 2'b00, 1, "R4 guard read");
        idle();

        // R5: wrap of 8 from 0x36, wrap of 16 from 0x4E
        beat(8'h36, 1'b1, 32'h8000_0036, 4'hF, 3'b010, 2'b10, 1, "R5 w8 wr 36");
        beat(8'h37, 1'b1, 32'h8000_0037, 4'hF, 3'b010, 2'b10, 0, "R5 w8 wr 37");
        beat(8'h30, 1'b1, 32'h8000_0030, 4'hF, 3'b111, 2'b10, 0, "R5 w8 wr 30");
        idle();
        beat(8'h36, 1'b0, 32'h0, 4'hF, 3'b010, 2'b10, 1, "R5 w8 rd 36");
        beat(8'h37, 1'b0, 32'h0, 4'hF, 3'b010, 2'b10, 0, "R5 w8 rd 37");
        beat(8'h30, 1'b0, 32'h0, 4'hF, 3'b111, 2'b10, 0, "R5 w8 rd 30");
        idle();
        beat(8'h4E, 1'b1, 32'h1600_004E, 4'hF, 3'b010, 2'b11, 1, "R5 w16 wr 4E");
        beat(8'h4F, 1'b1, 32'h1600_004F, 4'hF, 3'b010, 2'b11, 0, "R5 w16 wr 4F");
        beat(8'h40, 1'b1, 32'h1600_0040, 4'hF, 3'b111, 2'b11, 0, "R5 w16 wr 40");
        idle();
        beat(8'h4F, 1'b0, 32'h0, 4'hF, 3'b010, 2'b11, 1, "R5 w16 rd 4F");
        beat(8'h40, 1'b0, 32'h0, 4'hF, 3'b111, 2'b11, 0, "R5 w16 rd 40");
        idle();

        // R7 / R8 setup: words 0x60..0x63
        beat(8'h60, 1'b1, 32'h6000_0000, 4'hF, 3'b010, 2'b00, 1, "R7 fill 60");
        beat(8'h61, 1'b1, 32'h6000_0001, 4'hF, 3'b010, 2'b00, 0, "R7 fill 61");
        beat(8'h62, 1'b1, 32'h6000_0002, 4'hF, 3'b010, 2'b00, 0, "R7 fill 62");
        beat(8'h63, 1'b1, 32'h6000_0003, 4'hF, 3'b111, 2'b00, 0, "R7 fill 63");
        idle();

        // R7: jump away from the predicted address
        beat(8'h60, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 1, "R7 rd 60");
        beat(8'h62, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 1, "R7 jump 62");
        beat(8'h63, 1'b0, 32'h0, 4'hF, 3'b111, 2'b00, 0, "R7 resume 63");
        idle();

        // R8: release cyc mid-burst
        beat(8'h60, 1'b0, 32'h0, 4'hF, 3'b010, 2'b00, 1, "R8 rd 60");
        @(posedge clk); #1; cyc = 1'b0; adr = 8'h61;
        @(negedge clk);
        check(ack_o == 1'b0, "R8 no ack while released", 32'(ack_o), 32'h0);
        beat(8'h61, 1'b0, 32'h0, 4'hF, 3'b111, 2'b00, 1, "R8 restart 61");
        idle();

        // R9: writes then reads in one wrap-4 burst
        beat(8'h50, 1'b1, 32'h9000_0050, 4'hF, 3'b010, 2'b01, 1, "R9 wr 50");
        beat(8'h51, 1'b1, 32'h9000_0051, 4'hF, 3'b010, 2'b01, 0, "R9 wr 51");
        beat(8'h52, 1'b1, 32'h9000_0052, 4'hF, 3'b010, 2'b01, 0, "R9 wr 52");
        beat(8'h53, 1'b1, 32'h9000_0053, 4'hF, 3'b010, 2'b01, 0, "R9 wr 53");
        beat(8'h50, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 0, "R9 rd 50");
        beat(8'h51, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 0, "R9 rd 51");
        beat(8'h52, 1'b0, 32'h0, 4'hF, 3'b010, 2'b01, 0, "R9 rd 52");
        beat(8'h53, 1'b0, 32'h0, 4'hF, 3'b111, 2'b01, 0, "R9 rd 53");
        idle();

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 reads left unanswered", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule